// File: doc/BRIEF.md
# Multiprocessor system interrupt router

The router gathers 32 level-sensitive peripheral request lines and one local-timer line per CPU, and turns them into a 16-bit priority-level vector for each CPU. Each source bit has a fixed four-bit priority level, set by a parameter table. A source whose level is zero is never recorded. The pending bits that are not masked by the disable register are folded into one-hot level bits. The result goes to a single CPU that software programs through the target register.

Software controls the router through a small word-addressed register port. There is one register for setting disable bits and one for clearing them, so no read-modify-write sequence is needed. Bit 31 of the disable register silences all peripheral traffic to the target CPU. A CPU's own timer always reaches that CPU at the timer's level, whichever CPU is the target. The timer also raises a shared pending bit that follows the normal routing path.

Top module: `irq_router`

## Requirements
- R1: A read of word 0 returns the pending register with bit 31 forced to 0.
- R2: A read of word 1 returns the disable register ANDed with the writable mask 0xF05DFF80.
- R3: A write to word 2 clears every disable bit that is set in (write data AND 0xF05DFF80), which enables those sources. Other disable bits keep their values.
- R4: A write to word 3 sets the disable bits, and clears the pending bits, selected by (write data AND 0xF05DFF80). A source that is still held high stays cleared until it is deasserted and asserted again.
- R5: Word 4 holds the target CPU number. A write stores write data bits [3:0], and a read returns that value zero-extended. A target number of NCPU or more routes peripheral levels to no CPU.
- R6: A rising edge of a source whose table level is nonzero sets its pending bit at the next clock edge. A falling edge clears the bit. A source with level 0 never sets a pending bit, so level-vector bit 0 stays 0.
- R7: When (pending AND NOT disable) is nonzero and disable bit 31 is 0, the target CPU's vector contains bit L for every enabled source whose table level is L. Every other CPU receives no peripheral bits.
- R8: A rising edge on timer input c sets the shared pending bit TIMER_BIT and holds level bit LEVEL_MAP[TIMER_BIT] on CPU c. A falling edge clears both. The disable register does not affect the per-CPU timer bit.
- R9: Reset loads the disable register with 0x0FA2007F, clears pending, sets the target to 0 and drives every level vector to 0.
- R10: The level vectors are registered. They change at the clock edge that follows the edge at which the pending, disable, target or timer state changed.
- R11: Reads of words 5 to 7 return 0, and writes to words 0, 1 and 5 to 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational, zero when no read is made |
| src_in | input | 32 | Peripheral request lines |
| tmr_in | input | NCPU | Per-CPU local timer request lines |
| lvl_out | output | NCPU*16 | Level vectors, CPU c in bits [16c+15:16c] |

## Verification
The assertions check the following on every cycle: read data never carries bits outside its register's range, undefined words read as zero, level bit 0 is never driven, at most one CPU carries peripheral level bits, and the vectors are quiet on the first cycle after reset. Three behaviours can only be shown by the bench's scenarios, which the reference model checks cycle by cycle: the exact fold of pending sources into levels, the interplay between set-to-disable and edge-tracked pending bits, and the one-edge lag of the registered outputs.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int          NCPU       = 4,
  parameter logic [127:0] LEVEL_MAP = 128'h0E980000_0E0FC401_DAB97653_20000000,
  parameter int          TIMER_BIT  = 14,
  parameter logic [31:0] VALID_MASK = 32'hF05DFF80,
  parameter logic [31:0] DIS_RESET  = 32'h0FA2007F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_rd,
  output logic [31:0]          reg_rdata,
  input  logic [31:0]          src_in,
  input  logic [NCPU-1:0]      tmr_in,
  output logic [NCPU*16-1:0]   lvl_out
);
  localparam int          NSRC   = 32;
  localparam int          LVW    = 16;
  localparam int          GDIS   = 31;
  localparam logic [3:0]  TMR_LV = LEVEL_MAP[4*TIMER_BIT +: 4];
  localparam logic [31:0] TBIT   = 32'(1) << TIMER_BIT;

  logic [31:0]         pend, dis, src_q;
  logic [3:0]          tgt;
  logic [NCPU-1:0]     tmr_q, tmr_hold;
  logic [NSRC-1:0]     live;
  logic [LVW-1:0]      ext_vec;

  for (genvar i = 0; i < NSRC; i++) begin : g_live
    assign live[i] = |LEVEL_MAP[4*i +: 4];
  end

  wire [NCPU-1:0] tmr_rise = tmr_in & ~tmr_q;
  wire [NCPU-1:0] tmr_fall = ~tmr_in & tmr_q;
  wire [31:0] rise  = ((src_in & ~src_q) | ({32{|tmr_rise}} & TBIT)) & live;
  wire [31:0] fall  = ((~src_in & src_q) | ({32{|tmr_fall}} & TBIT)) & live & ~rise;
  wire [31:0] wmask = reg_wdata & VALID_MASK;
  wire wr_en  = reg_wr && reg_addr == 3'd2;
  wire wr_dis = reg_wr && reg_addr == 3'd3;
  wire wr_tgt = reg_wr && reg_addr == 3'd4;

  wire [31:0] enabled = pend & ~dis;
  wire        ext_on  = (|enabled) && !dis[GDIS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= '0;
      dis      <= DIS_RESET;
      tgt      <= '0;
      src_q    <= '0;
      tmr_q    <= '0;
      tmr_hold <= '0;
    end else begin
      pend  <= ((pend | rise) & ~fall) & ~(wr_dis ? wmask : 32'd0);
      src_q <= src_in;
      tmr_q <= tmr_in;
      tmr_hold <= (tmr_hold | tmr_rise) & ~tmr_fall;
      if (wr_en)  dis <= dis & ~wmask;
      if (wr_dis) dis <= dis | wmask;
      if (wr_tgt) tgt <= reg_wdata[3:0];
    end
  end

  always_comb begin
    ext_vec = '0;
    for (int j = 0; j < NSRC; j++)
      if (enabled[j]) ext_vec = ext_vec | (LVW'(1) << LEVEL_MAP[4*j +: 4]);
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    wire [LVW-1:0] nxt = ((ext_on && tgt == 4'(c)) ? ext_vec : '0)
                       | (tmr_hold[c] ? (LVW'(1) << TMR_LV) : '0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_out[c*LVW +: LVW] <= '0;
      else        lvl_out[c*LVW +: LVW] <= nxt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        3'd0:    reg_rdata = pend & ~(32'(1) << GDIS);
        3'd1:    reg_rdata = dis & VALID_MASK;
        3'd4:    reg_rdata = {28'd0, tgt};
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int          NCPU       = 4,
  parameter logic [127:0] LEVEL_MAP = 128'h0,
  parameter int          TIMER_BIT  = 14,
  parameter logic [31:0] VALID_MASK = 32'hF05DFF80
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         reg_addr,
  input logic               reg_rd,
  input logic [31:0]        reg_rdata,
  input logic [NCPU*16-1:0] lvl_out
);
  localparam logic [15:0] TMASK = 16'(1) << LEVEL_MAP[4*TIMER_BIT +: 4];

  logic [NCPU-1:0] has_ext, has_l0;
  for (genvar c = 0; c < NCPU; c++) begin : g_c
    assign has_ext[c] = |(lvl_out[c*16 +: 16] & ~TMASK);
    assign has_l0[c]  = lvl_out[c*16];
  end

  AST_RD_PEND_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd0) |-> !reg_rdata[31]); // R1
  AST_RD_DIS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd1) |-> (reg_rdata & ~VALID_MASK) == 32'd0); // R2
  AST_RD_TGT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd4) |-> reg_rdata[31:4] == 28'd0); // R5
  AST_RD_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr > 3'd4) |-> reg_rdata == 32'd0); // R11
  AST_LVL0_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
    has_l0 == '0); // R6
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(has_ext) <= 1); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> lvl_out == '0); // R9
endmodule

bind irq_router irq_router_chk #(
  .NCPU(NCPU), .LEVEL_MAP(LEVEL_MAP), .TIMER_BIT(TIMER_BIT), .VALID_MASK(VALID_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
  .reg_rdata(reg_rdata), .lvl_out(lvl_out)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
  localparam int          NCPU = 4;
  localparam logic [127:0] MAP = 128'h0E980000_0E0FC401_DAB97653_20000000;
  localparam int          TB   = 14;
  localparam logic [31:0] MASK = 32'hF05DFF80;

  logic clk = 0, rst_n = 0;
  logic [2:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, src_in = 0;
  logic [NCPU-1:0] tmr_in = 0;
  logic [NCPU*16-1:0] lvl_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_router #(.NCPU(NCPU), .LEVEL_MAP(MAP), .TIMER_BIT(TB)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .src_in(src_in), .tmr_in(tmr_in), .lvl_out(lvl_out));

  function automatic int lv(int j);
    return int'(MAP[4*j +: 4]);
  endfunction

  // behavioural reference
  logic [31:0] m_pend, m_dis, m_sq;
  logic [3:0]  m_tgt;
  logic [NCPU-1:0] m_tq, m_th;
  logic [15:0] m_exp [NCPU];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_dis = 32'h0FA2007F; m_tgt = 0; m_sq = 0; m_tq = 0; m_th = 0;
      for (int c = 0; c < NCPU; c++) m_exp[c] = 0;
    end else begin
      bit anyr, anyf, r, f;
      logic [31:0] d;
      for (int c = 0; c < NCPU; c++) begin
        logic [15:0] e;
        e = 0;
        if (c == int'(m_tgt) && (m_pend & ~m_dis) != 0 && !m_dis[31])
          for (int j = 0; j < 32; j++)
            if (m_pend[j] && !m_dis[j]) e[lv(j)] = 1'b1;
        if (m_th[c]) e[lv(TB)] = 1'b1;
        m_exp[c] = e;
      end
      anyr = 0; anyf = 0;
      for (int c = 0; c < NCPU; c++) begin
        if (tmr_in[c] && !m_tq[c]) begin anyr = 1; m_th[c] = 1; end
        if (!tmr_in[c] && m_tq[c]) begin anyf = 1; m_th[c] = 0; end
      end
      for (int j = 0; j < 32; j++) if (lv(j) != 0) begin
        r = (src_in[j] && !m_sq[j]) || (j == TB && anyr);
        f = ((!src_in[j] && m_sq[j]) || (j == TB && anyf)) && !r;
        if (r) m_pend[j] = 1; else if (f) m_pend[j] = 0;
      end
      d = reg_wdata & MASK;
      if (reg_wr) case (reg_addr)
        3'd2: m_dis = m_dis & ~d;
        3'd3: begin m_dis = m_dis | d; m_pend = m_pend & ~d; end
        3'd4: m_tgt = reg_wdata[3:0];
        default: ;
      endcase
      m_sq = src_in; m_tq = tmr_in;
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_pend & 32'h7FFFFFFF;
      3'd1: return m_dis & MASK;
      3'd4: return {28'd0, m_tgt};
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      for (int c = 0; c < NCPU; c++)
        check("R7/R8/R10 model cpu level", 32'(lvl_out[c*16 +: 16]), 32'(m_exp[c]));
      if (reg_rd) check("R1/R2/R5/R11 model read", reg_rdata, m_read(reg_addr));
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #2 check(tag, reg_rdata, exp);
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic lvl(int c, logic [15:0] exp, string tag);
    #2 check(tag, 32'(lvl_out[c*16 +: 16]), 32'(exp));
  endtask

  task automatic settle;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    lvl(0, 16'h0, "R9 reset level cpu0");
    rd(1, 32'h0, "R9 reset disable reads masked");
    rd(0, 32'h0, "R9 reset pending");
    rd(4, 32'h0, "R9 reset target");
    wr(3, 32'hFFFFFFFF);
    rd(1, 32'hF05DFF80, "R4 set all disables");
    wr(2, 32'h0000FF80);
    rd(1, 32'hF05D0000, "R3 partial enable");
    wr(2, 32'hFFFFFFFF);
    rd(1, 32'h0, "R2 all enabled");
    @(negedge clk); src_in[8] = 1; settle();
    lvl(0, 16'h0008, "R7 level 3 on cpu0");
    lvl(1, 16'h0000, "R7 non-target quiet");
    @(negedge clk); src_in[17] = 1; settle();
    rd(0, 32'h00000100, "R6 level-0 source ignored");
    wr(4, 32'h12);
    lvl(2, 16'h0000, "R10 target change lags one edge");
    @(negedge clk);
    lvl(2, 16'h0008, "R5 retarget to cpu2");
    lvl(0, 16'h0000, "R5 old target quiet");
    rd(4, 32'h2, "R5 target low bits");
    src_in[20] = 1; src_in[12] = 1; settle();
    lvl(2, 16'h8208, "R7 three sources folded");
    wr(3, 32'h80000000); @(negedge clk);
    lvl(2, 16'h0000, "R7 global disable");
    rd(1, 32'h80000000, "R2 global disable bit");
    wr(2, 32'h80000000); @(negedge clk);
    lvl(2, 16'h8208, "R7 global enable");
    wr(3, 32'h00001000); @(negedge clk);
    rd(0, 32'h00100100, "R4 pending bit cleared");
    wr(2, 32'h00001000); @(negedge clk);
    lvl(2, 16'h8008, "R4 held source stays cleared");
    @(negedge clk); src_in[12] = 0; @(negedge clk); src_in[12] = 1; settle();
    lvl(2, 16'h8208, "R6 re-assert sets pending");
    @(negedge clk); src_in[8] = 0; settle();
    lvl(2, 16'h8200, "R6 deassert clears pending");
    wr(5, 32'hFFFFFFFF); wr(0, 32'hFFFFFFFF);
    rd(5, 32'h0, "R11 undefined word reads zero");
    rd(1, 32'h0, "R11 writes to undefined words ignored");
    rd(0, 32'h00101000, "R11 pending untouched");
    @(negedge clk); tmr_in[1] = 1; settle();
    lvl(1, 16'h0400, "R8 timer level on own cpu");
    lvl(2, 16'h8600, "R8 shared timer bit routed");
    rd(0, 32'h00105000, "R8 timer pending bit");
    wr(3, 32'h00004000); @(negedge clk);
    lvl(1, 16'h0400, "R8 timer bit ignores disable");
    lvl(2, 16'h8200, "R8 disabled shared bit");
    @(negedge clk); tmr_in[1] = 0; settle();
    lvl(1, 16'h0000, "R8 timer release");
    wr(4, 32'h1F); @(negedge clk);
    rd(4, 32'hF, "R5 only four bits kept");
    for (int c = 0; c < NCPU; c++) lvl(c, 16'h0, "R5 out-of-range target");
    wr(4, 0);
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      reg_wr = 0; reg_rd = 0;
      if ($urandom_range(3) == 0) src_in[$urandom_range(31)] ^= 1'b1;
      if ($urandom_range(15) == 0) tmr_in[$urandom_range(NCPU-1)] ^= 1'b1;
      if ($urandom_range(7) == 0) begin
        reg_wr = 1; reg_addr = 3'($urandom_range(7));
        reg_wdata = ($urandom_range(3) == 0) ? 32'($urandom_range(7)) : $urandom;
      end else if ($urandom_range(3) == 0) begin
        reg_rd = 1; reg_addr = 3'($urandom_range(7));
      end
    end
    @(negedge clk); reg_wr = 0; reg_rd = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule